// File: doc/BRIEF.md
# ACPI Sleep-State Power Sequencer

This block is the digital control core of a motherboard power-rail manager. Two active-low sleep-control pins pick the platform state: active (S0, S1/S2), suspend-to-RAM (S3), or soft-off (S4/S5). Two strap inputs shape the result. One strap keeps the 5 V dual rail alive in soft-off. The other decides whether the auxiliary low-voltage rail stays on during sleep. From the state and the straps the block drives per-rail enable and source-select strobes for four rails. The rails are a 3.3 V dual rail, a 5 V dual rail, an internal 1.2 V rail and an auxiliary rail.

Analog comparators outside the block deliver their results as level flags. These are standby power-on, main 3.3 V and 5 V input good, per-rail power-good, two temperature levels and a soft-start shutdown. Every asynchronous input passes through a synchronizer before use. Entry into the active state waits for a long, unbroken period in which the main supplies are good. Entry into sleep waits for a shorter debounce. A rail undervoltage counts only once it has lasted a timeout. Undervoltage, over-temperature and shutdown feed a single latched fault flag.

All intervals are parameters in clock cycles. The defaults assume a 200 MHz clock: about 53 ms qualification, 200 us sleep delay and 10 us undervoltage timeout.

Top module: `acpi_pwr_seq`

## Requirements
- R1: While reset is held, all enables and the fault flag are 0. When the synchronized standby POR flag is low or the soft-start shutdown flag is high, every enable is forced to 0 and the control state restarts in soft-off.
- R2: The requested state is decoded from the synchronized sleep pins with a priority. `slp_s5_n`=0 gives soft-off whatever `slp_s3_n` is. Otherwise `slp_s3_n`=0 gives S3. Both high gives active.
- R3: The state moves from sleep to active only after ACT_QUAL_CYC consecutive cycles in which active is requested and both `main3_ok` and `main5_ok` are high. Any break restarts the count.
- R4: The state leaves active only after a sleep request has persisted for SLP_DLY_CYC consecutive cycles. A move between S3 and soft-off takes effect with no delay.
- R5: `dual3_en` is 1 whenever the block is not forced off. `dual3_src_main` is 1 in active and 0 in both sleep states.
- R6: `dual5_main_en` is 1 only in active. `dual5_sb_en` is 1 in S3, and in soft-off only when `opt_keep5`=1. The two are never 1 together.
- R7: `vid_en` is 1 only in active.
- R8: `aux_en` is 1 in active. In both sleep states it equals `mode_aux_all`.
- R9: A low `rail_pg` bit raises the fault only after it has stayed low for UV_TMO_CYC cycles while its rail is enabled. Shorter dips are ignored, and so are dips on rails that are disabled. Rail bits are 0 for the 3.3 V dual, 1 for the 5 V dual (either source), 2 for 1.2 V and 3 for aux.
- R10: `temp_warn` sets the fault and leaves the enables alone. `temp_crit` sets the fault and forces every enable to 0 for as long as it stays high, without changing the state.
- R11: The fault stays set until the synchronized standby POR flag goes low or soft-start shutdown goes high. Clearing takes priority over setting.
- R12: Each asynchronous input passes through SYNC_STAGES flops, and each output is registered. With the default two stages, a change on a strap, shutdown or temperature input shows at the outputs after the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp_s3_n | input | 1 | Active-low suspend-to-RAM request |
| slp_s5_n | input | 1 | Active-low soft-off request |
| opt_keep5 | input | 1 | Keep 5 V dual from standby in soft-off |
| mode_aux_all | input | 1 | Keep aux rail on in sleep states |
| sb_por_ok | input | 1 | Standby supply above POR threshold |
| main3_ok | input | 1 | Main 3.3 V input above threshold |
| main5_ok | input | 1 | Main 5 V input above threshold |
| rail_pg | input | 4 | Per-rail power-good flags (see R9) |
| temp_warn | input | 1 | Die temperature above fault level |
| temp_crit | input | 1 | Die temperature above shutdown level |
| ss_shdn | input | 1 | Soft-start pin held in shutdown |
| dual3_en | output | 1 | 3.3 V dual rail enable |
| dual3_src_main | output | 1 | 3.3 V dual fed from main input (else standby) |
| dual5_main_en | output | 1 | 5 V dual fed from main 5 V switch |
| dual5_sb_en | output | 1 | 5 V dual fed from standby switch |
| vid_en | output | 1 | Internal 1.2 V rail enable |
| aux_en | output | 1 | Auxiliary rail enable |
| fault | output | 1 | Latched fault flag |

## Verification
Each result has its own due cycle, counted from the clock period in which an input is driven. A strap, shutdown, POR or temperature change is due at the third rising edge. An S3/soft-off switch is due at the fourth. The move to active is due at ACT_QUAL_CYC+3 edges, counted from the last moment the conditions became true. The move to sleep is due at SLP_DLY_CYC+3 edges, and an undervoltage fault at UV_TMO_CYC+3 edges. The bench drives on falling edges and samples on the falling edge after the due rising edge. For every timed path it also samples one edge earlier to prove the result is not early.

// File: rtl/acpi_seq_pkg.sv
package acpi_seq_pkg;

   typedef enum logic [1:0] {
      PST_OFF  = 2'd0,
      PST_STR  = 2'd1,
      PST_ACT  = 2'd2
   } pstate_e;

   localparam int RAIL_N   = 4;
   localparam int RAIL_D3  = 0;
   localparam int RAIL_D5  = 1;
   localparam int RAIL_VID = 2;
   localparam int RAIL_AUX = 3;

   typedef struct packed {
      logic d3_en;
      logic d3_main;
      logic d5_main;
      logic d5_sb;
      logic vid_en;
      logic aux_en;
   } rail_ctl_t;

   // soft-off request has priority over suspend-to-RAM
   function automatic pstate_e decode_req(input logic s3_n, input logic s5_n);
      if (!s5_n)      return PST_OFF;
      else if (!s3_n) return PST_STR;
      else            return PST_ACT;
   endfunction

endpackage

// File: rtl/acpi_seq_sync.sv
module acpi_seq_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("acpi_seq_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("acpi_seq_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/acpi_seq_state.sv
module acpi_seq_state
   import acpi_seq_pkg::*;
#(
   parameter int ACT_QUAL_CYC = 10_600_000,
   parameter int SLP_DLY_CYC  = 40_000
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    restart,
   input  pstate_e req,
   input  logic    mains_ok,
   output pstate_e st
);

   localparam int QW = $clog2(ACT_QUAL_CYC + 1);
   localparam int DW = $clog2(SLP_DLY_CYC + 1);
   localparam logic [QW-1:0] Q_LAST = QW'(ACT_QUAL_CYC - 1);
   localparam logic [DW-1:0] D_LAST = DW'(SLP_DLY_CYC - 1);

   generate
      if (ACT_QUAL_CYC < 1) begin : g_bad_qual
         $error("acpi_seq_state: ACT_QUAL_CYC must be at least 1");
      end
      if (SLP_DLY_CYC < 1) begin : g_bad_dly
         $error("acpi_seq_state: SLP_DLY_CYC must be at least 1");
      end
   endgenerate

   logic [QW-1:0] qcnt;
   logic [DW-1:0] dcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= PST_OFF;
         qcnt <= '0;
         dcnt <= '0;
      end else if (restart) begin
         st   <= PST_OFF;
         qcnt <= '0;
         dcnt <= '0;
      end else if (st == PST_ACT) begin
         qcnt <= '0;
         if (req != PST_ACT) begin
            if (dcnt == D_LAST) begin
               st   <= req;
               dcnt <= '0;
            end else begin
               dcnt <= dcnt + 1'b1;
            end
         end else begin
            dcnt <= '0;
         end
      end else begin
         dcnt <= '0;
         if (req == PST_ACT && mains_ok) begin
            if (qcnt == Q_LAST) begin
               st   <= PST_ACT;
               qcnt <= '0;
            end else begin
               qcnt <= qcnt + 1'b1;
            end
         end else begin
            qcnt <= '0;
            // sleep-to-sleep moves are immediate
            if (req != PST_ACT) st <= req;
         end
      end
   end

endmodule

// File: rtl/acpi_seq_uvflt.sv
module acpi_seq_uvflt #(
   parameter int TMO_CYC = 2_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic pg,
   output logic uv
);

   localparam int CW = $clog2(TMO_CYC + 1);
   localparam logic [CW-1:0] C_TOP = CW'(TMO_CYC);

   generate
      if (TMO_CYC < 1) begin : g_bad_tmo
         $error("acpi_seq_uvflt: TMO_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!armed || pg)   cnt <= '0;
      else if (cnt != C_TOP)   cnt <= cnt + 1'b1;
   end

   assign uv = (cnt == C_TOP);

endmodule

// File: rtl/acpi_seq_decode.sv
module acpi_seq_decode
   import acpi_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      kill,
   input  pstate_e   st,
   input  logic      keep5,
   input  logic      aux_all,
   output rail_ctl_t ctl
);

   rail_ctl_t nxt;

   always_comb begin
      nxt = '0;
      if (!kill) begin
         unique case (st)
            PST_ACT: begin
               nxt.d3_en   = 1'b1;
               nxt.d3_main = 1'b1;
               nxt.d5_main = 1'b1;
               nxt.vid_en  = 1'b1;
               nxt.aux_en  = 1'b1;
            end
            PST_STR: begin
               nxt.d3_en   = 1'b1;
               nxt.d5_sb   = 1'b1;
               nxt.aux_en  = aux_all;
            end
            default: begin
               nxt.d3_en   = 1'b1;
               nxt.d5_sb   = keep5;
               nxt.aux_en  = aux_all;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl <= '0;
      else        ctl <= nxt;
   end

endmodule

// File: rtl/acpi_pwr_seq.sv
module acpi_pwr_seq
   import acpi_seq_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int ACT_QUAL_CYC = 10_600_000,
   parameter int SLP_DLY_CYC  = 40_000,
   parameter int UV_TMO_CYC   = 2_000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   slp_s3_n,
   input  logic                   slp_s5_n,
   input  logic                   opt_keep5,
   input  logic                   mode_aux_all,
   input  logic                   sb_por_ok,
   input  logic                   main3_ok,
   input  logic                   main5_ok,
   input  logic [RAIL_N-1:0]      rail_pg,
   input  logic                   temp_warn,
   input  logic                   temp_crit,
   input  logic                   ss_shdn,
   output logic                   dual3_en,
   output logic                   dual3_src_main,
   output logic                   dual5_main_en,
   output logic                   dual5_sb_en,
   output logic                   vid_en,
   output logic                   aux_en,
   output logic                   fault
);

   localparam int SYNC_W = 10 + RAIL_N;

   logic [SYNC_W-1:0] raw_bus, syn_bus;
   logic              s3n_s, s5n_s, keep5_s, auxall_s, por_s;
   logic              m3_s, m5_s, twarn_s, tcrit_s, ss_s;
   logic [RAIL_N-1:0] pg_s;

   assign raw_bus = {slp_s3_n, slp_s5_n, opt_keep5, mode_aux_all, sb_por_ok,
                     main3_ok, main5_ok, temp_warn, temp_crit, ss_shdn, rail_pg};

   acpi_seq_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_bus),
      .q     (syn_bus)
   );

   assign {s3n_s, s5n_s, keep5_s, auxall_s, por_s,
           m3_s, m5_s, twarn_s, tcrit_s, ss_s, pg_s} = syn_bus;

   logic    restart_s, kill_s, mains_ok_s, req_act, st_act;
   pstate_e req_st, st;

   assign restart_s  = !por_s || ss_s;
   assign kill_s     = restart_s || tcrit_s;
   assign mains_ok_s = m3_s && m5_s;
   assign req_st     = decode_req(s3n_s, s5n_s);
   assign req_act    = (req_st == PST_ACT);

   acpi_seq_state #(.ACT_QUAL_CYC(ACT_QUAL_CYC), .SLP_DLY_CYC(SLP_DLY_CYC)) i_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart_s),
      .req      (req_st),
      .mains_ok (mains_ok_s),
      .st       (st)
   );

   assign st_act = (st == PST_ACT);

   rail_ctl_t ctl;

   acpi_seq_decode i_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .kill    (kill_s),
      .st      (st),
      .keep5   (keep5_s),
      .aux_all (auxall_s),
      .ctl     (ctl)
   );

   logic [RAIL_N-1:0] rail_on, uv_q;
   logic              uv_any;

   assign rail_on[RAIL_D3]  = ctl.d3_en;
   assign rail_on[RAIL_D5]  = ctl.d5_main || ctl.d5_sb;
   assign rail_on[RAIL_VID] = ctl.vid_en;
   assign rail_on[RAIL_AUX] = ctl.aux_en;

   generate
      for (genvar gi = 0; gi < RAIL_N; gi++) begin : g_uv
         acpi_seq_uvflt #(.TMO_CYC(UV_TMO_CYC)) i_uvflt (
            .clk   (clk),
            .rst_n (rst_n),
            .armed (rail_on[gi]),
            .pg    (pg_s[gi]),
            .uv    (uv_q[gi])
         );
      end
   endgenerate

   assign uv_any = |uv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          fault <= 1'b0;
      else if (restart_s)                  fault <= 1'b0;
      else if (uv_any || twarn_s || tcrit_s) fault <= 1'b1;
   end

   assign dual3_en       = ctl.d3_en;
   assign dual3_src_main = ctl.d3_main;
   assign dual5_main_en  = ctl.d5_main;
   assign dual5_sb_en    = ctl.d5_sb;
   assign vid_en         = ctl.vid_en;
   assign aux_en         = ctl.aux_en;

endmodule

// File: rtl/acpi_pwr_seq_chk.sv
module acpi_pwr_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic dual3_en,
   input logic dual5_main_en,
   input logic dual5_sb_en,
   input logic vid_en,
   input logic aux_en,
   input logic fault,
   input logic kill_s,
   input logic restart_s,
   input logic uv_any,
   input logic twarn_s,
   input logic tcrit_s,
   input logic st_act,
   input logic req_act,
   input logic mains_ok_s
);

   assert_kill_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      kill_s |=> !(dual3_en || dual5_main_en || dual5_sb_en || vid_en || aux_en));

   assert_qualified_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_act) |-> $past(req_act && mains_ok_s));

   assert_d5_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(dual5_main_en && dual5_sb_en));

   assert_vid_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vid_en |-> $past(st_act));

   assert_fault_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault) |-> $past(uv_any || twarn_s || tcrit_s));

   assert_fault_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && !restart_s) |=> fault);

   assert_fault_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      restart_s |=> !fault);

endmodule

bind acpi_pwr_seq acpi_pwr_seq_chk i_acpi_pwr_seq_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .dual3_en      (dual3_en),
   .dual5_main_en (dual5_main_en),
   .dual5_sb_en   (dual5_sb_en),
   .vid_en        (vid_en),
   .aux_en        (aux_en),
   .fault         (fault),
   .kill_s        (kill_s),
   .restart_s     (restart_s),
   .uv_any        (uv_any),
   .twarn_s       (twarn_s),
   .tcrit_s       (tcrit_s),
   .st_act        (st_act),
   .req_act       (req_act),
   .mains_ok_s    (mains_ok_s)
);

// File: tb/test_acpi_pwr_seq.sv
`timescale 1ns/1ps
module test_acpi_pwr_seq;

   localparam int Q = 64;
   localparam int D = 16;
   localparam int T = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n, s3n, s5n, opt, mode, por, m3, m5, tw, tc, ss;
   logic [3:0] pg;
   logic       dual3_en, dual3_src_main, dual5_main_en, dual5_sb_en, vid_en, aux_en, fault;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   acpi_pwr_seq #(
      .SYNC_STAGES(2), .ACT_QUAL_CYC(Q), .SLP_DLY_CYC(D), .UV_TMO_CYC(T)
   ) i_acpi_pwr_seq (
      .clk(clk), .rst_n(rst_n), .slp_s3_n(s3n), .slp_s5_n(s5n),
      .opt_keep5(opt), .mode_aux_all(mode), .sb_por_ok(por),
      .main3_ok(m3), .main5_ok(m5), .rail_pg(pg), .temp_warn(tw),
      .temp_crit(tc), .ss_shdn(ss), .dual3_en(dual3_en),
      .dual3_src_main(dual3_src_main), .dual5_main_en(dual5_main_en),
      .dual5_sb_en(dual5_sb_en), .vid_en(vid_en), .aux_en(aux_en),
      .fault(fault)
   );

   // {dual3_en, dual3_src_main, dual5_main_en, dual5_sb_en, vid_en, aux_en}
   wire [5:0] en_vec = {dual3_en, dual3_src_main, dual5_main_en, dual5_sb_en, vid_en, aux_en};

   localparam logic [5:0] EN_ACT = 6'b111011;

   // {slp_s3_n, slp_s5_n, opt_keep5, mode_aux_all, expected en_vec}
   localparam logic [9:0] VEC [8] = '{
      {4'b1000, 6'b100000},
      {4'b1010, 6'b100100},
      {4'b1001, 6'b100001},
      {4'b1011, 6'b100101},
      {4'b0100, 6'b100100},
      {4'b0111, 6'b100101},
      {4'b0101, 6'b100101},
      {4'b0010, 6'b100100}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; s3n = 1'b0; s5n = 1'b0; opt = 1'b0; mode = 1'b0;
      por = 1'b1; m3 = 1'b1; m5 = 1'b1; tw = 1'b0; tc = 1'b0; ss = 1'b0;
      pg = 4'hF;
      tick(3);
      chk("R1 enables in reset", 8'(en_vec), 8'h00);
      chk("R1 fault in reset", 8'(fault), 8'h00);
      rst_n = 1'b1;
      tick(4);
      chk("R5 soft-off after reset", 8'(en_vec), 8'b100000);

      // sleep-state decode table, R2/R6/R8
      for (int i = 0; i < 8; i++) begin
         {s3n, s5n, opt, mode} = VEC[i][9:6];
         tick(4);
         chk($sformatf("R2 R6 R8 sleep vector %0d", i), 8'(en_vec), 8'(VEC[i][5:0]));
      end
      opt = 1'b0; mode = 1'b0;

      // R3: qualification with an interruption
      s3n = 1'b1; s5n = 1'b1;
      tick(10);
      m5 = 1'b0;
      tick(1);
      m5 = 1'b1;
      tick(Q + 2);
      chk("R3 not active before interval", 8'(vid_en), 8'h00);
      tick(1);
      chk("R3 active after interval", 8'(en_vec), 8'(EN_ACT));

      // R9: glitch shorter than timeout
      pg[2] = 1'b0;
      tick(T - 1);
      pg[2] = 1'b1;
      tick(T + 4);
      chk("R9 short dip ignored", 8'(fault), 8'h00);

      // R9: dip at timeout
      pg[2] = 1'b0;
      tick(T + 2);
      chk("R9 no fault before timeout", 8'(fault), 8'h00);
      tick(1);
      chk("R9 fault at timeout", 8'(fault), 8'h01);
      pg[2] = 1'b1;
      tick(6);
      chk("R11 fault latched", 8'(fault), 8'h01);
      chk("R9 enables kept on uv", 8'(en_vec), 8'(EN_ACT));

      // R1/R11: soft-start shutdown
      ss = 1'b1;
      tick(3);
      chk("R1 shutdown forces off", 8'(en_vec), 8'h00);
      chk("R11 shutdown clears fault", 8'(fault), 8'h00);
      ss = 1'b0;
      tick(3);
      chk("R1 restart in soft-off", 8'(en_vec), 8'b100000);
      tick(Q);
      chk("R3 requalified after shutdown", 8'(en_vec), 8'(EN_ACT));

      // R4: active to sleep delay
      s3n = 1'b0;
      tick(D + 2);
      chk("R4 active held during delay", 8'(vid_en), 8'h01);
      tick(1);
      chk("R4 S3 after delay", 8'(en_vec), 8'b100100);

      // R9: disabled rails masked
      pg[2] = 1'b0; pg[3] = 1'b0;
      tick(3 * T + 4);
      chk("R9 disabled rail uv masked", 8'(fault), 8'h00);
      pg = 4'hF;
      tick(2);

      // R4: S3 to soft-off without delay
      s5n = 1'b0;
      tick(3);
      chk("R4 S3 kept one edge", 8'(en_vec), 8'b100100);
      tick(1);
      chk("R4 soft-off without delay", 8'(en_vec), 8'b100000);

      // R10: temperature warning
      tw = 1'b1;
      tick(1);
      tw = 1'b0;
      tick(2);
      chk("R10 warn sets fault", 8'(fault), 8'h01);
      chk("R10 warn keeps enables", 8'(en_vec), 8'b100000);

      // R1/R11: standby POR loss
      por = 1'b0;
      tick(3);
      chk("R1 por loss forces off", 8'(en_vec), 8'h00);
      chk("R11 por loss clears fault", 8'(fault), 8'h00);
      por = 1'b1;
      tick(3);
      chk("R5 dual rail back with por", 8'(en_vec), 8'b100000);

      // R10: critical temperature
      opt = 1'b1;
      tick(4);
      tc = 1'b1;
      tick(3);
      chk("R10 crit forces off", 8'(en_vec), 8'h00);
      chk("R10 crit sets fault", 8'(fault), 8'h01);
      tc = 1'b0;
      tick(3);
      chk("R10 enables return after crit", 8'(en_vec), 8'b100100);
      chk("R11 fault held after crit", 8'(fault), 8'h01);

      // R12: strap latency
      mode = 1'b1;
      tick(2);
      chk("R12 strap not seen before third edge", 8'(aux_en), 8'h00);
      tick(1);
      chk("R12 strap seen at third edge", 8'(aux_en), 8'h01);

      // R9: enabled sleep rail undervoltage
      ss = 1'b1;
      tick(3);
      ss = 1'b0;
      tick(3);
      pg[1] = 1'b0;
      tick(T + 2);
      chk("R9 sleep rail no fault before timeout", 8'(fault), 8'h00);
      tick(1);
      chk("R9 sleep rail fault at timeout", 8'(fault), 8'h01);
      pg[1] = 1'b1;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule